// File: doc/BRIEF.md
# CEC Bus Idle Wait Gate

This block decides when a CEC transmitter may begin driving a new message onto the shared line. The line engine supplies a tick every half nominal data-bit period. The block counts those ticks from a chosen start point and, once the programmed idle span has passed, grants a pending host start request with a single-cycle strobe to the transmit sequencer.

The span is set by a 3-bit wait code. Code 0 selects a standard-driven default whose length depends on how the previous message went. Codes 1 to 7 give a programmed span in half-bit steps. The count is restarted whenever the line is seen low before the span has run out.

An option bit chooses where the count starts. With the bit clear, it starts at the host's start request. With the bit set, it starts at the end of every transmitted or received message. The host's end-of-message flag, which must be raised no later than the start request for a one-byte message, is passed along with the grant.

Top module: `cec_idle_wait`

## Requirements
- R1: After reset the block is counting (`counting`=1) from zero, `start_ok`=0 and `start_last`=0.
- R2: With `wait_code`=0 the span is 6 half-bit ticks if `last_failed`=1. Otherwise it is 14 ticks if `same_initiator`=1, and 10 ticks if neither is set. `last_failed` takes priority.
- R3: With `wait_code`=n (1..7) the span is 2n-1 half-bit ticks, which is 0.5 + (n-1) bit periods.
- R4: With `auto_start`=1, a `tx_done` or `rx_done` pulse restarts the count at zero, and `som_req` does not restart it. A request raised after the span has run out is granted in the next cycle.
- R5: A cycle with `line_idle`=0 while counting restarts the count at zero. Such a cycle overrides a tick in the same cycle.
- R6: `start_ok` lasts one cycle. It is given only while a start request is pending, and it consumes that request.
- R7: `start_last` is 1 in the grant cycle exactly when `eom_req` was seen after the previous grant and no later than the grant. A one-byte message raises it before or together with `som_req`.
- R8: `enable`=0 clears the count and drops any pending start and end requests. No grant follows from a request made before the clear.
- R9: With `auto_start`=0, `som_req` restarts the count at zero, and `tx_done` and `rx_done` have no effect.
- R10: After a grant the block idles (`counting`=0, no `start_ok`) until a new start point occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears state |
| wait_code | input | 3 | Idle span code (0 = standard default) |
| auto_start | input | 1 | 1: count starts at message end; 0: at start request |
| som_req | input | 1 | Host start-of-message request pulse |
| eom_req | input | 1 | Host end-of-message request pulse |
| tx_done | input | 1 | End-of-transmission pulse |
| rx_done | input | 1 | End-of-reception pulse |
| half_tick | input | 1 | One pulse per half nominal bit period |
| line_idle | input | 1 | Sampled bus level, 1 = released/high |
| last_failed | input | 1 | Previous attempt lost arbitration or failed |
| same_initiator | input | 1 | Next message comes from the previous initiator |
| start_ok | output | 1 | Single-cycle grant: bus free, start allowed |
| start_last | output | 1 | With grant: end-of-message flag is set |
| counting | output | 1 | Idle span currently being counted |

## Verification
The assertions check the following on every cycle. A grant never lasts two cycles and always consumes the pending request. A low line or a cleared enable zeroes the count. The start point chosen by `auto_start` resets the count. The exact span lengths for every code and default class, the end-of-message pairing, and the lasting absence of grants after a clear or after a grant can only be shown by the bench's scenarios. The bench shows them against its per-cycle reference model and its measured tick counts.

// File: rtl/iw_pkg.sv
package iw_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    IW_IDLE = 2'd0,
    IW_RUN  = 2'd1,
    IW_FREE = 2'd2
  } iw_state_e;

  // Span in half-bit ticks for a programmed code (1..7).
  function automatic int unsigned code_halves(input logic [CODE_W-1:0] code);
    return (int'(code) << 1) - 1;
  endfunction

  // Span in half-bit ticks for the standard default mode.
  function automatic int unsigned default_halves(
    input logic fail, input logic same,
    input int unsigned fail_bits, input int unsigned new_bits,
    input int unsigned same_bits);
    int unsigned bits;
    if (fail)      bits = fail_bits;
    else if (same) bits = same_bits;
    else           bits = new_bits;
    return bits * 2;
  endfunction

  // Largest span the counter must hold.
  function automatic int unsigned max_halves(
    input int unsigned fail_bits, input int unsigned new_bits,
    input int unsigned same_bits);
    int unsigned m;
    m = code_halves({CODE_W{1'b1}});
    if (2 * fail_bits > m) m = 2 * fail_bits;
    if (2 * new_bits > m)  m = 2 * new_bits;
    if (2 * same_bits > m) m = 2 * same_bits;
    return m;
  endfunction

endpackage

// File: rtl/iw_target.sv
module iw_target #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned FAIL_BITS = 3,
  parameter int unsigned NEW_BITS  = 5,
  parameter int unsigned SAME_BITS = 7
) (
  input  logic [iw_pkg::CODE_W-1:0] wait_code,
  input  logic                      last_failed,
  input  logic                      same_initiator,
  output logic [CNT_W-1:0]          target
);
  logic [CNT_W-1:0] prog_w;
  logic [CNT_W-1:0] dflt_w;

  always_comb begin
    prog_w = CNT_W'(iw_pkg::code_halves(wait_code));
    dflt_w = CNT_W'(iw_pkg::default_halves(last_failed, same_initiator,
                                           FAIL_BITS, NEW_BITS, SAME_BITS));
    target = (wait_code == '0) ? dflt_w : prog_w;
  end
endmodule

// File: rtl/iw_counter.sv
module iw_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic             line_low,
  input  logic             tick,
  input  logic             consume,
  input  logic [CNT_W-1:0] target,
  output logic             free_o,
  output logic             counting_o,
  output logic [CNT_W-1:0] count_o
);
  import iw_pkg::*;

  iw_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc_w;
  logic             reach_w;

  assign cnt_inc_w = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign reach_w   = cnt_inc_w >= {1'b0, target};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IW_RUN;
      cnt_q   <= '0;
    end else if (!enable || restart) begin
      state_q <= IW_RUN;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        IW_RUN: begin
          if (line_low) begin
            cnt_q <= '0;
          end else if (tick) begin
            if (!(&cnt_q)) cnt_q <= cnt_inc_w[CNT_W-1:0];
            if (reach_w) state_q <= IW_FREE;
          end
        end
        IW_FREE: if (consume) state_q <= IW_IDLE;
        default: state_q <= state_q;
      endcase
    end
  end

  assign free_o     = (state_q == IW_FREE);
  assign counting_o = (state_q == IW_RUN);
  assign count_o    = cnt_q;
endmodule

// File: rtl/iw_request.sv
module iw_request (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic som_req,
  input  logic eom_req,
  input  logic consume,
  output logic som_pend,
  output logic eom_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      som_pend <= 1'b0;
      eom_pend <= 1'b0;
    end else if (!enable) begin
      som_pend <= 1'b0;
      eom_pend <= 1'b0;
    end else if (consume) begin
      som_pend <= som_req;
      eom_pend <= eom_req;
    end else begin
      som_pend <= som_pend | som_req;
      eom_pend <= eom_pend | eom_req;
    end
  end
endmodule

// File: rtl/cec_idle_wait.sv
module cec_idle_wait #(
  parameter int unsigned FAIL_BITS = 3,
  parameter int unsigned NEW_BITS  = 5,
  parameter int unsigned SAME_BITS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [2:0] wait_code,
  input  logic       auto_start,
  input  logic       som_req,
  input  logic       eom_req,
  input  logic       tx_done,
  input  logic       rx_done,
  input  logic       half_tick,
  input  logic       line_idle,
  input  logic       last_failed,
  input  logic       same_initiator,
  output logic       start_ok,
  output logic       start_last,
  output logic       counting
);
  localparam int unsigned MAX_H = iw_pkg::max_halves(FAIL_BITS, NEW_BITS, SAME_BITS);
  localparam int unsigned CNT_W = $clog2(MAX_H + 1);

  logic [CNT_W-1:0] target_w;
  logic [CNT_W-1:0] count_w;
  logic             restart_w;
  logic             grant_w;
  logic             free_w;
  logic             som_pend_w;
  logic             eom_pend_w;

  // Start point selection.
  assign restart_w = auto_start ? (tx_done | rx_done) : som_req;
  assign grant_w   = free_w & som_pend_w;

  iw_target #(
    .CNT_W(CNT_W), .FAIL_BITS(FAIL_BITS),
    .NEW_BITS(NEW_BITS), .SAME_BITS(SAME_BITS)
  ) u_target (
    .wait_code      (wait_code),
    .last_failed    (last_failed),
    .same_initiator (same_initiator),
    .target         (target_w)
  );

  iw_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .restart    (restart_w),
    .line_low   (~line_idle),
    .tick       (half_tick),
    .consume    (grant_w),
    .target     (target_w),
    .free_o     (free_w),
    .counting_o (counting),
    .count_o    (count_w)
  );

  iw_request u_request (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .som_req  (som_req),
    .eom_req  (eom_req),
    .consume  (grant_w),
    .som_pend (som_pend_w),
    .eom_pend (eom_pend_w)
  );

  assign start_ok   = grant_w;
  assign start_last = grant_w & eom_pend_w;
endmodule

// File: rtl/iw_checker.sv
module iw_checker #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             auto_start,
  input logic             som_req,
  input logic             tx_done,
  input logic             rx_done,
  input logic             line_idle,
  input logic             start_ok,
  input logic             counting,
  input logic             som_pend,
  input logic [CNT_W-1:0] cnt
);
  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !start_ok); // R6
  AST_GRANT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && !som_req) |=> !som_pend); // R6
  AST_LINE_LOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !line_idle) |=> (cnt == '0)); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0 && !som_pend && !start_ok)); // R8
  AST_AUTO_START_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && auto_start && (tx_done || rx_done)) |=> (counting && cnt == '0)); // R4
  AST_HOST_START_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !auto_start && som_req) |=> (counting && cnt == '0)); // R9
endmodule

bind cec_idle_wait iw_checker #(.CNT_W(CNT_W)) u_iw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .auto_start (auto_start),
  .som_req    (som_req),
  .tx_done    (tx_done),
  .rx_done    (rx_done),
  .line_idle  (line_idle),
  .start_ok   (start_ok),
  .counting   (counting),
  .som_pend   (som_pend_w),
  .cnt        (count_w)
);

// File: tb/cec_idle_wait_bench.sv
module cec_idle_wait_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [2:0] wait_code = 3'd0;
  logic auto_start = 1'b0;
  logic som_req = 1'b0, eom_req = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
  logic half_tick = 1'b0, line_idle = 1'b1;
  logic last_failed = 1'b0, same_initiator = 1'b0;
  logic start_ok, start_last, counting;

  int checks = 0;
  int fails = 0;
  int phase = 0;
  bit last_tick = 0;
  bit done_flag = 0;

  // reference model state: 0 idle, 1 running, 2 free
  int m_state = 1;
  int m_cnt = 0;
  bit m_som = 0, m_eom = 0;

  always #4 clk = ~clk;

  cec_idle_wait u_cec_idle_wait (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wait_code(wait_code),
    .auto_start(auto_start), .som_req(som_req), .eom_req(eom_req),
    .tx_done(tx_done), .rx_done(rx_done), .half_tick(half_tick),
    .line_idle(line_idle), .last_failed(last_failed),
    .same_initiator(same_initiator), .start_ok(start_ok),
    .start_last(start_last), .counting(counting)
  );

  function automatic int ref_span(input int code, input bit f, input bit s);
    if (code != 0) return code + code - 1;
    if (f) return 6;
    return s ? 14 : 10;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    bit grant, restart;
    if (!rst_n || !enable) begin
      m_state = 1; m_cnt = 0; m_som = 0; m_eom = 0;
    end else begin
      grant   = (m_state == 2) && m_som;
      restart = auto_start ? (tx_done || rx_done) : som_req;
      if (restart) begin
        m_state = 1; m_cnt = 0;
      end else if (m_state == 1) begin
        if (!line_idle) m_cnt = 0;
        else if (half_tick) begin
          m_cnt++;
          if (m_cnt >= ref_span(wait_code, last_failed, same_initiator)) m_state = 2;
        end
      end else if (m_state == 2 && grant) m_state = 0;
      if (grant) begin
        m_som = som_req; m_eom = eom_req;
      end else begin
        m_som = m_som | som_req; m_eom = m_eom | eom_req;
      end
    end
  end

  // compare against the model every cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done_flag) begin
      bit e_ok;
      e_ok = (m_state == 2) && m_som;
      chk(start_ok == e_ok, "R6 model start_ok", start_ok, e_ok);
      chk(start_last == (e_ok && m_eom), "R7 model start_last", start_last, e_ok && m_eom);
      chk(counting == (m_state == 1), "R10 model counting", counting, m_state == 1);
    end
  end

  task automatic cyc();
    half_tick = (phase == 3);
    last_tick = half_tick;
    phase = (phase + 1) % 4;
    @(negedge clk);
  endtask

  task automatic pulse_som(input bit with_eom);
    som_req = 1'b1; eom_req = with_eom;
    cyc();
    som_req = 1'b0; eom_req = 1'b0;
  endtask

  // counts ticks until start_ok shows up
  task automatic measure(output int ticks, output bit got);
    ticks = 0; got = 0;
    for (int i = 0; i < 300; i++) begin
      cyc();
      if (last_tick) ticks++;
      if (start_ok) begin got = 1; break; end
    end
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1600000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int t; bit g; int seen;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(counting == 1'b1, "R1 counting after reset", counting, 1);
    chk(start_ok == 1'b0, "R1 start_ok after reset", start_ok, 0);
    chk(start_last == 1'b0, "R1 start_last after reset", start_last, 0);
    enable = 1'b1;
    cyc();

    // R3 / R9: programmed codes, count starts at the host request
    for (int n = 1; n <= 7; n++) begin
      wait_code = 3'(n);
      pulse_som(1'b0);
      measure(t, g);
      chk(g, "R3 grant seen", g, 1);
      chk(t == 2 * n - 1, "R3 span ticks", t, 2 * n - 1);
      chk(start_last == 1'b0, "R7 no eom flag", start_last, 0);
      cyc();
      chk(start_ok == 1'b0, "R6 single-cycle grant", start_ok, 0);
    end

    // R2: default spans by class
    wait_code = 3'd0;
    last_failed = 1'b1; same_initiator = 1'b1;
    pulse_som(1'b0); measure(t, g);
    chk(t == 6, "R2 default after failure", t, 6);
    last_failed = 1'b0;
    pulse_som(1'b0); measure(t, g);
    chk(t == 14, "R2 default same initiator", t, 14);
    same_initiator = 1'b0;
    pulse_som(1'b0); measure(t, g);
    chk(t == 10, "R2 default new initiator", t, 10);

    // R7: one-byte message, eom raised before som
    wait_code = 3'd1;
    eom_req = 1'b1; cyc(); eom_req = 1'b0;
    pulse_som(1'b0); measure(t, g);
    chk(g && start_last, "R7 eom before som", start_last, 1);

    // R5: low line restarts the span
    wait_code = 3'd3;
    pulse_som(1'b0);
    for (int i = 0; i < 10; i++) cyc();
    line_idle = 1'b0; cyc(); line_idle = 1'b1;
    measure(t, g);
    chk(t == 5, "R5 span after line low", t, 5);

    // R10 / R9: idle after grant, done pulses ignored in host-start mode
    tx_done = 1'b1; cyc(); tx_done = 1'b0;
    rx_done = 1'b1; cyc(); rx_done = 1'b0;
    seen = 0;
    for (int i = 0; i < 80; i++) begin cyc(); if (start_ok || counting) seen++; end
    chk(seen == 0, "R9 done pulses ignored / R10 idle", seen, 0);

    // R4: auto start at end of message
    auto_start = 1'b1; wait_code = 3'd2;
    tx_done = 1'b1; cyc(); tx_done = 1'b0;
    for (int i = 0; i < 30; i++) cyc();
    pulse_som(1'b0);
    chk(start_ok == 1'b1, "R4 request after expiry granted", start_ok, 1);
    rx_done = 1'b1; som_req = 1'b1; cyc(); rx_done = 1'b0; som_req = 1'b0;
    measure(t, g);
    chk(t == 3, "R4 span from rx end", t, 3);
    tx_done = 1'b1; cyc(); tx_done = 1'b0;
    for (int i = 0; i < 5; i++) cyc();
    pulse_som(1'b0);
    measure(t, g);
    chk(g && t < 3, "R4 som does not restart", t, 2);

    // R8: clearing enable drops a pending request
    auto_start = 1'b0; wait_code = 3'd7;
    pulse_som(1'b1);
    for (int i = 0; i < 8; i++) cyc();
    enable = 1'b0; cyc(); enable = 1'b1;
    seen = 0;
    for (int i = 0; i < 120; i++) begin cyc(); if (start_ok) seen++; end
    chk(seen == 0, "R8 request dropped by disable", seen, 0);
    chk(counting == 1'b0, "R8 span done without grant", counting, 0);

    cyc(); cyc();
    finish_run();
  end
endmodule